// File: doc/BRIEF.md
# Receiver Gain Controller with Dwell Timer

This block decides whether the low-noise amplifier of an amplitude-keyed radio receiver runs in its high-gain or its attenuated low-gain state. Each cycle of the crystal reference clock it compares a digitised signal-strength code against two thresholds. When the code reaches the upper threshold, the attenuator is switched in at once. The attenuator is removed only after the code has stayed below a separate, lower threshold for a whole dwell interval of 2^k reference cycles. The interval keeps on-off keyed data, whose two levels lie on either side of the threshold, from flipping the gain on every bit.

A 3-bit select either turns gain control off (the amplifier then stays in high gain) or picks k from seven odd values. Whenever the gain state changes, and whenever the receiver is powered up or re-entered from transmit, the block raises a track request for a fixed number of cycles. The request tells the baseband peak detectors to follow the new signal level. The signal-strength code is a continuous sample taken every cycle, so it carries no valid/ready handshake and has no back-pressure. All pins are plain level signals.

Top module: `agc_gain_ctrl`

## Requirements
- R1: With `dwell_sel` = 3'b000, `low_gain` is 0 at every clock edge, whatever the signal-strength code.
- R2: With `dwell_sel` = s, for s from 1 to 7, the dwell length is 2^k reference cycles with k = 2*s + 9 (s = 1 gives 2048, s = 2 gives 8192, s = 3 gives 32768).
- R3: While active and in high gain, a sample with `rssi_code` >= HI_THR sets `low_gain` at that clock edge. A code between LO_THR and HI_THR-1 leaves the gain state unchanged.
- R4: In low gain, `low_gain` clears at the edge that samples the 2^k-th consecutive code below LO_THR. It stays set at every earlier edge.
- R5: In low gain, a sample >= LO_THR ends the run of low samples. The next sample below LO_THR starts a new full count of 2^k.
- R6: The block is active only while `chip_en` = 1 and `tx_sel` = 0. While inactive, `low_gain` is 0 after every edge and the dwell count is cleared.
- R7: A change of `low_gain` in either direction raises `track_req` at the same edge, for TRACK_CYC cycles.
- R8: A 0-to-1 change of `chip_en` raises `track_req` at the edge that samples it, for TRACK_CYC cycles.
- R9: A 1-to-0 change of `tx_sel` (entry into receive) raises `track_req` at the edge that samples it, for TRACK_CYC cycles.
- R10: A new trigger while `track_req` is high restarts the full TRACK_CYC count.
- R11: While `rst_n` = 0 at an edge, `low_gain` and `track_req` are 0 and all counts are cleared. Reset records the enable history as low, so `chip_en` = 1 at the first edge after reset raises `track_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rssi_code | input | RSSI_W | Digitised signal-strength sample, taken every cycle |
| dwell_sel | input | SEL_W | 0 turns gain control off; 1..7 choose the dwell exponent |
| chip_en | input | 1 | Receiver enable |
| tx_sel | input | 1 | 1 selects transmit, 0 selects receive |
| low_gain | output | 1 | 1 switches in the amplifier attenuator |
| track_req | output | 1 | Requests the peak detectors to follow the signal |

## Verification
Both outputs are registered. A stimulus sampled at clock edge N shows up on `low_gain` and `track_req` just after edge N, with no further delay, and `track_req` then stays high through edge N+TRACK_CYC-1. The bench applies each input vector half a cycle before an edge and advances its own cycle model at that edge. It compares both outputs at the following falling edge, so every result is checked in exactly the cycle it is due. Long directed runs count out full dwell windows for k = 11, 13 and 15, including a run that a sample at LO_THR interrupts and restarts.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic {GAIN_HIGH = 1'b0, GAIN_LOW = 1'b1} gain_e;

  // dwell exponent for a non-zero select: odd steps above a base
  function automatic int unsigned dwell_exp(input int unsigned sel, input int unsigned base);
    return base + 2 * sel;
  endfunction
endpackage

// File: rtl/agc_level_cmp.sv
module agc_level_cmp #(
  parameter int RSSI_W = 8,
  parameter logic [RSSI_W-1:0] HI_THR = 8'd160,
  parameter logic [RSSI_W-1:0] LO_THR = 8'd85
) (
  input  logic [RSSI_W-1:0] rssi_code,
  output logic              at_hi,
  output logic              below_lo
);
  always_comb begin
    at_hi    = (rssi_code >= HI_THR);
    below_lo = (rssi_code <  LO_THR);
  end
endmodule

// File: rtl/agc_dwell_ctrl.sv
module agc_dwell_ctrl
  import agc_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int K_BASE = 9,
  parameter int CNT_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  input  logic             at_hi,
  input  logic             below_lo,
  output logic             low_gain,
  output logic             gain_flip
);
  localparam int EXP_W = $clog2(CNT_W + 1);

  gain_e            state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0] k_exp;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    k_exp    = EXP_W'(dwell_exp(int'(sel), K_BASE));
    last_cnt = ({{(CNT_W-1){1'b0}}, 1'b1} << k_exp) - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!active) begin
      state_d = GAIN_HIGH;
      cnt_d   = '0;
    end else if (state_q == GAIN_HIGH) begin
      cnt_d = '0;
      if (at_hi) state_d = GAIN_LOW;
    end else if (!below_lo) begin
      cnt_d = '0;
    end else if (cnt_q == last_cnt) begin
      state_d = GAIN_HIGH;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GAIN_HIGH;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign low_gain  = (state_q == GAIN_LOW);
  assign gain_flip = rst_n && (state_d != state_q);
endmodule

// File: rtl/agc_track_gen.sv
module agc_track_gen #(
  parameter int TRACK_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic tx_sel,
  input  logic gain_flip,
  output logic track_req
);
  localparam int TC_W = $clog2(TRACK_CYC + 1);

  logic            en_q, tx_q, trig;
  logic [TC_W-1:0] left_q;

  assign trig = gain_flip || (chip_en && !en_q) || (!tx_sel && tx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tx_q   <= tx_sel;
      left_q <= '0;
    end else begin
      en_q <= chip_en;
      tx_q <= tx_sel;
      if (trig)             left_q <= TC_W'(TRACK_CYC);
      else if (left_q != 0) left_q <= left_q - {{(TC_W-1){1'b0}}, 1'b1};
    end
  end

  assign track_req = (left_q != '0);
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl #(
  parameter int RSSI_W    = 8,
  parameter int SEL_W     = 3,
  parameter int K_BASE    = 9,
  parameter logic [RSSI_W-1:0] HI_THR = 8'd160,
  parameter logic [RSSI_W-1:0] LO_THR = 8'd85,
  parameter int TRACK_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSSI_W-1:0] rssi_code,
  input  logic [SEL_W-1:0]  dwell_sel,
  input  logic              chip_en,
  input  logic              tx_sel,
  output logic              low_gain,
  output logic              track_req
);
  localparam int MAX_K = K_BASE + 2 * ((1 << SEL_W) - 1);
  localparam int CNT_W = MAX_K + 1;

  logic at_hi, below_lo, active, gain_flip;

  assign active = chip_en && !tx_sel && (dwell_sel != '0);

  agc_level_cmp #(.RSSI_W(RSSI_W), .HI_THR(HI_THR), .LO_THR(LO_THR)) u_cmp (
    .rssi_code(rssi_code), .at_hi(at_hi), .below_lo(below_lo)
  );

  agc_dwell_ctrl #(.SEL_W(SEL_W), .K_BASE(K_BASE), .CNT_W(CNT_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .active(active), .sel(dwell_sel),
    .at_hi(at_hi), .below_lo(below_lo), .low_gain(low_gain), .gain_flip(gain_flip)
  );

  agc_track_gen #(.TRACK_CYC(TRACK_CYC)) u_track (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .tx_sel(tx_sel),
    .gain_flip(gain_flip), .track_req(track_req)
  );
endmodule

// File: rtl/agc_gain_ctrl_chk.sv
module agc_gain_ctrl_chk #(
  parameter int RSSI_W = 8,
  parameter int SEL_W  = 3,
  parameter logic [RSSI_W-1:0] HI_THR = 8'd160,
  parameter logic [RSSI_W-1:0] LO_THR = 8'd85
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RSSI_W-1:0] rssi_code,
  input logic [SEL_W-1:0]  dwell_sel,
  input logic              chip_en,
  input logic              tx_sel,
  input logic              low_gain,
  input logic              track_req
);
  logic act;
  assign act = chip_en && !tx_sel && (dwell_sel != '0);

  // R1
  a_r1_off_high_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (dwell_sel == '0) |=> !low_gain);
  // R6
  a_r6_inactive_high_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en || tx_sel) |=> !low_gain);
  // R3
  a_r3_cut_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (act && rssi_code >= HI_THR) |=> low_gain);
  a_r3_rise_needs_upper: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_gain) |-> $past(rssi_code >= HI_THR));
  // R4, R5
  a_r4_hold_at_or_above_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (low_gain && act && rssi_code >= LO_THR) |=> low_gain);
  // R7
  a_r7_track_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (low_gain != $past(low_gain)) |-> track_req);
  // R8
  a_r8_track_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_en) |=> track_req);
  // R9
  a_r9_track_on_rx_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_sel) |=> track_req);
endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(
  .RSSI_W(RSSI_W), .SEL_W(SEL_W), .HI_THR(HI_THR), .LO_THR(LO_THR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rssi_code(rssi_code), .dwell_sel(dwell_sel),
  .chip_en(chip_en), .tx_sel(tx_sel), .low_gain(low_gain), .track_req(track_req)
);

// File: tb/agc_gain_ctrl_tb_top.sv
module agc_gain_ctrl_tb_top;
  localparam logic [7:0] HI = 8'd160;
  localparam logic [7:0] LO = 8'd85;
  localparam int TRK = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rssi = '0;
  logic [2:0] sel = '0;
  logic en = 1'b0, tx = 1'b0;
  logic low_gain, track_req;

  int vectors = 0, misses = 0, cycles = 0;

  // bench model state
  bit m_gain = 0, m_en_q = 0, m_tx_q = 0;
  int unsigned m_run = 0, m_trk = 0;

  always #5 clk = ~clk;

  agc_gain_ctrl #(.HI_THR(HI), .LO_THR(LO), .TRACK_CYC(TRK)) dut_i (
    .clk(clk), .rst_n(rst_n), .rssi_code(rssi), .dwell_sel(sel),
    .chip_en(en), .tx_sel(tx), .low_gain(low_gain), .track_req(track_req)
  );

  function automatic int unsigned dwell_len(input logic [2:0] s);
    return 32'd1 << (2 * int'(s) + 9);
  endfunction

  task automatic model_edge();
    bit prev, on;
    if (!rst_n) begin
      m_gain = 0; m_run = 0; m_trk = 0; m_en_q = 0; m_tx_q = tx;
      return;
    end
    prev = m_gain;
    on = en && !tx && (sel != 0);
    if (!on) begin
      m_gain = 0; m_run = 0;
    end else if (!m_gain) begin
      m_run = 0;
      if (rssi >= HI) m_gain = 1;
    end else if (rssi >= LO) begin
      m_run = 0;
    end else begin
      m_run++;
      if (m_run == dwell_len(sel)) begin m_gain = 0; m_run = 0; end
    end
    if ((m_gain != prev) || (en && !m_en_q) || (!tx && m_tx_q)) m_trk = TRK;
    else if (m_trk != 0) m_trk--;
    m_en_q = en; m_tx_q = tx;
  endtask

  task automatic step(input logic [7:0] r, input logic [2:0] s, input logic e,
                      input logic t, input string tag);
    rssi = r; sel = s; en = e; tx = t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vectors++;
    if (low_gain !== m_gain) begin
      misses++;
      $display("FAIL %s cycle %0d: low_gain=%0b expected %0b", tag, cycles, low_gain, m_gain);
    end
    if (track_req !== (m_trk != 0)) begin
      misses++;
      $display("FAIL %s cycle %0d: track_req=%0b expected %0b", tag, cycles, track_req, m_trk != 0);
    end
  endtask

  task automatic run(input int n, input logic [7:0] r, input logic [2:0] s,
                     input logic e, input logic t, input string tag);
    for (int i = 0; i < n; i++) step(r, s, e, t, tag);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      misses++;
      $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'h5eed_a6c1));
    @(negedge clk);
    // R11: reset clears both outputs
    run(4, 8'd255, 3'd1, 1'b1, 1'b0, "R11 reset");
    rst_n = 1'b1;
    run(30, 8'd40, 3'd1, 1'b1, 1'b0, "R11 R8 release with enable high");
    // R1: control off
    run(40, 8'd255, 3'd0, 1'b1, 1'b0, "R1 agc off");
    // R3: band between thresholds holds high gain
    run(10, LO, 3'd1, 1'b1, 1'b0, "R3 at lower");
    run(10, HI - 8'd1, 3'd1, 1'b1, 1'b0, "R3 just under upper");
    // R3 / R7: cut and track
    run(30, HI, 3'd1, 1'b1, 1'b0, "R3 R7 cut");
    // R4 / R2 k=11 dwell
    run(2047, 8'd20, 3'd1, 1'b1, 1'b0, "R4 dwell k11 early");
    run(30, 8'd20, 3'd1, 1'b1, 1'b0, "R4 R7 dwell k11 end");
    // R5: interruption at LO restarts the run
    run(5, 8'd200, 3'd1, 1'b1, 1'b0, "R5 cut");
    run(1000, LO - 8'd1, 3'd1, 1'b1, 1'b0, "R5 partial");
    run(1, LO, 3'd1, 1'b1, 1'b0, "R5 interrupt");
    run(2047, 8'd0, 3'd1, 1'b1, 1'b0, "R5 restart early");
    run(2, 8'd0, 3'd1, 1'b1, 1'b0, "R5 restart end");
    // R10 / R8: retrigger while tracking
    run(10, 8'd200, 3'd1, 1'b1, 1'b0, "R10 cut");
    run(1, 8'd200, 3'd1, 1'b0, 1'b0, "R10 R6 enable low");
    run(12, 8'd200, 3'd1, 1'b0, 1'b0, "R6 disabled");
    run(30, 8'd200, 3'd1, 1'b1, 1'b0, "R8 R10 enable rise");
    // R9 / R6: transmit forces high gain; return to receive tracks
    run(40, 8'd255, 3'd1, 1'b1, 1'b1, "R6 transmit");
    run(30, 8'd10, 3'd1, 1'b1, 1'b0, "R9 rx entry");
    // R2: longer exponents
    run(3, HI, 3'd2, 1'b1, 1'b0, "R2 k13 cut");
    run(8191, 8'd50, 3'd2, 1'b1, 1'b0, "R2 k13 early");
    run(3, 8'd50, 3'd2, 1'b1, 1'b0, "R2 k13 end");
    run(3, HI, 3'd3, 1'b1, 1'b0, "R2 k15 cut");
    run(32767, 8'd50, 3'd3, 1'b1, 1'b0, "R2 k15 early");
    run(3, 8'd50, 3'd3, 1'b1, 1'b0, "R2 k15 end");
    // random blocks
    for (int b = 0; b < 14; b++) begin
      logic [2:0] s;
      int style;
      s = 3'(1 + ($urandom % 2));
      style = int'($urandom % 3);
      for (int i = 0; i < 3000; i++) begin
        logic [7:0] r;
        if (style == 0)      r = 8'($urandom);
        else if (style == 1) r = ((i / 8) % 2 == 0) ? 8'd200 : 8'd40;
        else                 r = ($urandom % 400 == 0) ? 8'd220 : 8'($urandom % 85);
        if ($urandom % 500 == 0) en = ~en;
        if ($urandom % 700 == 0) tx = ~tx;
        if ($urandom % 900 == 0) s = 3'($urandom);
        step(r, s, en, tx, "R1-R10 random mix");
      end
      en = 1'b1; tx = 1'b0;
    end
    finish_up();
  end
endmodule